// File: doc/BRIEF.md
# Aperture Address Remapper

This block sits in front of a bus interconnect and turns a 32-bit master address into a target choice and a target-side address. The address space is cut into sixteen equal windows of 256 MB each. The top four address bits pick the window. Every window carries two 4-bit fields. The first is the target number. The second is the window index to use inside that target, and it replaces the top four address bits. Two windows may therefore land on the same target at different places. A window may also be moved to a different index, so that, for example, window 8 reaches the bottom of a memory.

Software programs the map through a small word-addressed register port. Writes only touch a staging copy. The map in use changes only when a commit word is written, and every window changes in the same clock edge. Lookups are pipelined by one register. A window whose active target number is zero has no target, and a hit there is reported as a decode error.

Top module: `aperture_remap`

## Requirements
- R1: After reset, all four table registers read as zero, and a lookup of any address reports a decode error with target 0 and address 0.
- R2: The register port is word addressed with byte offsets. 0x00 holds the target fields of windows 0-7, 0x04 those of windows 8-15, 0x08 the index fields of windows 0-7 and 0x0C those of windows 8-15. Window w sits in bits [4*(w%8)+3 : 4*(w%8)] of its register. Reads are combinational and return the staging values.
- R3: A table write changes only the staging copy. Lookups keep using the previously committed map.
- R4: A write to offset 0x10 with data bit 0 set copies the whole staging map into the active map at that clock edge. A write there with bit 0 clear has no effect.
- R5: Offset 0x10 always reads as zero.
- R6: For a valid lookup that hits a mapped window w, the result carries target = active target of w and address = {active index of w, lk_addr[27:0]}.
- R7: For a valid lookup that hits a window whose active target is 0, res_derr is 1 and both res_slave and res_addr are 0.
- R8: res_valid equals lk_valid of the previous cycle. While res_valid is 0, res_derr, res_slave and res_addr are 0.
- R9: A lookup presented in the same cycle as a commit is translated with the map that was active before the commit.
- R10: A write whose offset has bits [1:0] non-zero, or whose offset is 0x14-0x1C, changes nothing, and those unused offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 5 | Register byte offset (write and read) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| lk_valid | input | 1 | Lookup request valid |
| lk_addr | input | 32 | Lookup request address |
| res_valid | output | 1 | Lookup result valid, one cycle after request |
| res_derr | output | 1 | Decode error: window has no target |
| res_slave | output | 4 | Target number of the hit window |
| res_addr | output | 32 | Translated target address |

## Verification
The assertions assume that reset is held for at least one clock edge before traffic and that lk_valid and cfg_we are low while it is held. They also assume that the inputs are steady around each rising edge. The bench changes inputs only on falling edges and keeps both request lines low during reset. Its random traffic mixes lookups with table writes, commits whose bit 0 is random, and the odd misaligned or unused offset. This drives every window through mapped, unmapped and re-indexed states while the checked properties stay valid.

// File: rtl/aperture_remap.sv
module aperture_remap #(
  parameter int AW  = 32,
  parameter int SW  = 4,
  parameter int CAW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [CAW-1:0] cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          lk_valid,
  input  logic [AW-1:0] lk_addr,
  output logic          res_valid,
  output logic          res_derr,
  output logic [SW-1:0] res_slave,
  output logic [AW-1:0] res_addr
);
  localparam int NAP = 1 << SW;
  localparam int TW  = NAP * SW;
  localparam int HW  = TW / 2;
  localparam int LOW = AW - SW;

  logic [TW-1:0] sh_sel_q, sh_off_q, ac_sel_q, ac_off_q;

  wire             aligned = (cfg_addr[1:0] == 2'b00);
  wire [CAW-3:0]   widx    = cfg_addr[CAW-1:2];
  wire [SW-1:0]    ap      = lk_addr[AW-1:LOW];
  wire [SW-1:0]    hit_sel = ac_sel_q[ap*SW +: SW];
  wire [SW-1:0]    hit_off = ac_off_q[ap*SW +: SW];
  wire             unmapped = (hit_sel == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_sel_q <= '0;
      sh_off_q <= '0;
      ac_sel_q <= '0;
      ac_off_q <= '0;
    end else if (cfg_we && aligned) begin
      case (widx)
        3'd0: sh_sel_q[HW-1:0]  <= cfg_wdata[HW-1:0];
        3'd1: sh_sel_q[TW-1:HW] <= cfg_wdata[HW-1:0];
        3'd2: sh_off_q[HW-1:0]  <= cfg_wdata[HW-1:0];
        3'd3: sh_off_q[TW-1:HW] <= cfg_wdata[HW-1:0];
        3'd4: if (cfg_wdata[0]) begin
          ac_sel_q <= sh_sel_q;
          ac_off_q <= sh_off_q;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (aligned) begin
      case (widx)
        3'd0: cfg_rdata[HW-1:0] = sh_sel_q[HW-1:0];
        3'd1: cfg_rdata[HW-1:0] = sh_sel_q[TW-1:HW];
        3'd2: cfg_rdata[HW-1:0] = sh_off_q[HW-1:0];
        3'd3: cfg_rdata[HW-1:0] = sh_off_q[TW-1:HW];
        default: cfg_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_derr  <= 1'b0;
      res_slave <= '0;
      res_addr  <= '0;
    end else begin
      res_valid <= lk_valid;
      res_derr  <= lk_valid && unmapped;
      res_slave <= lk_valid ? hit_sel : '0;
      res_addr  <= (lk_valid && !unmapped) ? {hit_off, lk_addr[LOW-1:0]} : '0;
    end
  end
endmodule

// File: rtl/aperture_remap_chk.sv
module aperture_remap_chk #(
  parameter int AW  = 32,
  parameter int SW  = 4,
  parameter int CAW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic [CAW-1:0] cfg_addr,
  input logic [31:0]    cfg_rdata,
  input logic           lk_valid,
  input logic [AW-1:0]  lk_addr,
  input logic           res_valid,
  input logic           res_derr,
  input logic [SW-1:0]  res_slave,
  input logic [AW-1:0]  res_addr
);
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);
  a_r8_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_derr && res_slave == '0 && res_addr == '0));
  a_r7_derr_no_target: assert property (@(posedge clk) disable iff (!rst_n)
    res_derr |-> (res_slave == '0 && res_addr == '0));
  a_r7_mapped_has_target: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_derr) |-> res_slave != '0);
  a_r6_low_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (res_derr || res_addr[AW-SW-1:0] == $past(lk_addr[AW-SW-1:0])));
  a_r5_commit_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == 5'h10) |-> cfg_rdata == 32'h0);
endmodule

bind aperture_remap aperture_remap_chk #(.AW(AW), .SW(SW), .CAW(CAW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .lk_valid(lk_valid), .lk_addr(lk_addr), .res_valid(res_valid),
  .res_derr(res_derr), .res_slave(res_slave), .res_addr(res_addr)
);

// File: tb/aperture_remap_tb_top.sv
`timescale 1ns/1ps
module aperture_remap_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic res_valid, res_derr;
  logic [3:0] res_slave;
  logic [31:0] res_addr;

  int n_tests = 0, n_fail = 0;
  logic [63:0] m_ssel = '0, m_soff = '0, m_asel = '0, m_aoff = '0;

  always #2.5 clk = ~clk;

  aperture_remap dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .res_valid(res_valid), .res_derr(res_derr),
    .res_slave(res_slave), .res_addr(res_addr)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [4:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (a[4:2])
      3'd0: return m_ssel[31:0];
      3'd1: return m_ssel[63:32];
      3'd2: return m_soff[31:0];
      3'd3: return m_soff[63:32];
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [36:0] exp_look(input logic v, input logic [31:0] a);
    logic [3:0] w, s, o;
    if (!v) return '0;
    w = a[31:28];
    s = m_asel[w*4 +: 4];
    o = m_aoff[w*4 +: 4];
    if (s == 4'h0) return {1'b1, 4'h0, 32'h0};
    return {1'b0, s, o, a[27:0]};
  endfunction

  task automatic model_write(input logic we, input logic [4:0] a, input logic [31:0] d);
    if (!we || a[1:0] != 2'b00) return;
    case (a[4:2])
      3'd0: m_ssel[31:0] = d;
      3'd1: m_ssel[63:32] = d;
      3'd2: m_soff[31:0] = d;
      3'd3: m_soff[63:32] = d;
      3'd4: if (d[0]) begin m_asel = m_ssel; m_aoff = m_soff; end
      default: ;
    endcase
  endtask

  task automatic step(input logic we, input logic [4:0] a, input logic [31:0] d,
                      input logic v, input logic [31:0] la);
    logic [36:0] e;
    cfg_we = we; cfg_addr = a; cfg_wdata = d; lk_valid = v; lk_addr = la;
    #1;
    chk(cfg_rdata == exp_read(a), "R2 read data", cfg_rdata, exp_read(a));
    e = exp_look(v, la);
    @(posedge clk);
    model_write(we, a, d);
    @(negedge clk);
    chk(res_valid == v, "R8 res_valid", res_valid, v);
    chk(res_derr == e[36], "R7 res_derr", res_derr, e[36]);
    chk(res_slave == e[35:32], "R6 res_slave", res_slave, e[35:32]);
    chk(res_addr == e[31:0], "R6 res_addr", res_addr, e[31:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [4:0] ra;
    process::self().srandom(32'h5eed_1234);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int r = 0; r < 4; r++) begin
      step(0, 5'(r*4), 0, 1, 32'(r) << 29);
      chk(cfg_rdata == 0, "R1 table reads zero", cfg_rdata, 0);
      chk(res_derr == 1 && res_slave == 0 && res_addr == 0, "R1 lookup derr", {res_derr, res_slave}, 5'h10);
    end

    // R3: staging only
    step(1, 5'h04, 32'h0000_0031, 0, 0);
    step(1, 5'h0C, 32'h0000_00F0, 0, 0);
    step(0, 5'h04, 0, 1, 32'h8123_4567);
    chk(cfg_rdata == 32'h31, "R3 staging readback", cfg_rdata, 32'h31);
    chk(res_derr == 1, "R3 uncommitted map unused", res_derr, 1);

    // R4: commit with bit 0 clear
    step(1, 5'h10, 32'hFFFF_FFFE, 0, 0);
    step(0, 5'h10, 0, 1, 32'h9AAA_0000);
    chk(res_derr == 1, "R4 bit0 clear no commit", res_derr, 1);
    chk(cfg_rdata == 0, "R5 commit reads zero", cfg_rdata, 0);

    // R9: commit and lookup same cycle
    step(1, 5'h10, 32'h1, 1, 32'h8123_4567);
    chk(res_derr == 1, "R9 same-cycle old map", res_derr, 1);
    step(0, 5'h00, 0, 1, 32'h8123_4567);
    chk(res_slave == 4'h1 && res_addr == 32'h0123_4567, "R6 window 8 to index 0", res_addr, 32'h0123_4567);
    step(0, 5'h00, 0, 1, 32'h9AAA_0000);
    chk(res_slave == 4'h3 && res_addr == 32'hFAAA_0000, "R6 window 9 to index F", res_addr, 32'hFAAA_0000);
    step(0, 5'h00, 0, 1, 32'h7000_0001);
    chk(res_derr == 1 && res_slave == 0 && res_addr == 0, "R7 unmapped window", {res_derr, res_slave}, 5'h10);

    // R10: misaligned and unused offsets
    step(1, 5'h01, 32'hFFFF_FFFF, 0, 0);
    step(1, 5'h14, 32'hFFFF_FFFF, 0, 0);
    step(0, 5'h00, 0, 0, 0);
    chk(cfg_rdata == 0, "R10 misaligned write ignored", cfg_rdata, 0);
    step(0, 5'h14, 0, 0, 0);
    chk(cfg_rdata == 0, "R10 unused offset reads zero", cfg_rdata, 0);
    step(0, 5'h04, 0, 0, 0);
    chk(cfg_rdata == 32'h31, "R10 table unchanged", cfg_rdata, 32'h31);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      case ($urandom % 8)
        0: ra = 5'h00; 1: ra = 5'h04; 2: ra = 5'h08; 3: ra = 5'h0C;
        4, 5: ra = 5'h10;
        6: ra = 5'($urandom);
        default: ra = 5'(($urandom % 4) * 4);
      endcase
      step(($urandom % 3) == 0, ra, $urandom, ($urandom % 4) != 0, $urandom);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule